// File: doc/BRIEF.md
# Digit-Serial Two's-Complement Adder/Subtractor

This block adds or subtracts two W-bit two's-complement operands that arrive N bits per clock, lowest digit first. Each cycle it sums the current digit of A, the current digit of B (bitwise inverted when subtracting) and a single stored carry bit. It registers the N-bit result digit and the new carry. A complete word takes W/N cycles, and the result leaves the block in the same digit order one cycle behind its inputs.

A start-of-word strobe marks the first digit of every word. On that digit the stored carry is discarded and replaced by the word's seed: 0 for addition, 1 for subtraction. The operation select is captured on that same digit and holds for the rest of the word. Words may follow one another with no gap. The only state carried across cycles is the carry bit and the captured operation. With N = 1 the block is a plain bit-serial adder/subtractor. W must be an integer multiple of N.

Top module: `dsas_addsub`

## Requirements
- R1: One clock edge after a digit is presented, `res_dig` equals the low N bits of `a_dig` + B' + carry-in. B' is `b_dig` in add mode and `~b_dig` in subtract mode.
- R2: `cout` is the carry out of that same sum, registered on the same edge. On a digit without the strobe, it is used as the carry-in of the least significant bit.
- R3: Over W/N consecutive digits, the result digits taken lowest first form (A + B) mod 2^W in add mode and (A - B) mod 2^W in subtract mode.
- R4: `add_mode` = 1 on the first digit selects addition. `add_mode` = 0 selects subtraction, which inverts every B digit.
- R5: When `sow` = 1, the stored carry has no effect. The carry-in is 0 for addition and 1 for subtraction, even when the previous word ended with a carry of the other value.
- R6: `add_mode` is sampled only when `sow` = 1. Changes on later digits of the same word do not alter the result.
- R7: With N = 1, the block behaves as a bit-serial adder/subtractor and produces the correct W-bit word over W cycles.
- R8: A synchronous active-high `rst` clears `res_dig` and `cout` to 0 on the next edge and selects addition as the held operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sow | input | 1 | Start-of-word strobe, high on the lowest digit of a word |
| add_mode | input | 1 | 1 = add, 0 = subtract; sampled when `sow` is high |
| a_dig | input | N | Current digit of operand A |
| b_dig | input | N | Current digit of operand B |
| res_dig | output | N | Registered result digit |
| cout | output | 1 | Registered carry out of the last digit processed |

## Verification
The carry out of one word's top digit and the forced seed of the next word's first digit compete for the same carry-in in the same cycle, because words run back to back. The bench sweeps every operand pair in both modes with no idle cycle between words. Many words therefore end with a carry opposite to the next word's seed, and R5 is judged by checking that the next word's first result digit uses the seed and not the stale carry. On some words `add_mode` is also inverted after the first digit, and the full-word value must still match the operation selected at the strobe.

// File: rtl/dsas_pkg.sv
package dsas_pkg;

    typedef enum logic {
        OP_SUB = 1'b0,
        OP_ADD = 1'b1
    } op_e;

    // carry seed injected on the first digit of a word
    function automatic logic seed_carry(input op_e op);
        return (op == OP_SUB);
    endfunction

    // whether the B digit is inverted for this operation
    function automatic logic invert_b(input op_e op);
        return (op == OP_SUB);
    endfunction

endpackage

// File: rtl/dsas_op_hold.sv
module dsas_op_hold
    import dsas_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sow,
    input  logic add_mode,
    output op_e  op_now
);
    op_e op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= OP_ADD;
        end else if (sow) begin
            op_q <= op_e'(add_mode);
        end
    end

    // the strobe digit uses the live select, later digits the captured one
    always_comb begin
        op_now = sow ? op_e'(add_mode) : op_q;
    end
endmodule

// File: rtl/dsas_digit_sum.sv
module dsas_digit_sum
    import dsas_pkg::*;
#(
    parameter int N = 2
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    input  op_e          op,
    output logic [N-1:0] sum,
    output logic         cout
);
    logic [N:0]   chain;
    logic [N-1:0] b_eff;
    logic         flip;

    assign flip     = invert_b(op);
    assign chain[0] = cin;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            assign b_eff[i]    = b[i] ^ flip;
            assign sum[i]      = a[i] ^ b_eff[i] ^ chain[i];
            assign chain[i+1]  = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
        end
    endgenerate

    assign cout = chain[N];
endmodule

// File: rtl/dsas_addsub.sv
module dsas_addsub
    import dsas_pkg::*;
#(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sow,
    input  logic         add_mode,
    input  logic [N-1:0] a_dig,
    input  logic [N-1:0] b_dig,
    output logic [N-1:0] res_dig,
    output logic         cout
);
    localparam int DIGITS = W / N;

    generate
        if (N < 1 || (W % N) != 0 || DIGITS < 1) begin : g_bad_cfg
            $error("word length must be a positive multiple of the digit size");
        end
    endgenerate

    typedef struct packed {
        logic [N-1:0] dig;
        logic         c;
    } step_t;

    op_e   op_now;
    logic  carry_in;
    step_t nxt;
    step_t cur_q;

    dsas_op_hold u_op (
        .clk     (clk),
        .rst     (rst),
        .sow     (sow),
        .add_mode(add_mode),
        .op_now  (op_now)
    );

    // the first digit discards the stored carry and takes the seed
    assign carry_in = sow ? seed_carry(op_now) : cur_q.c;

    dsas_digit_sum #(.N(N)) u_sum (
        .a   (a_dig),
        .b   (b_dig),
        .cin (carry_in),
        .op  (op_now),
        .sum (nxt.dig),
        .cout(nxt.c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt;
        end
    end

    assign res_dig = cur_q.dig;
    assign cout    = cur_q.c;
endmodule

// File: rtl/dsas_addsub_chk.sv
module dsas_addsub_chk #(
    parameter int N = 2
) (
    input logic         clk,
    input logic         rst,
    input logic         sow,
    input logic         add_mode,
    input logic [N-1:0] a_dig,
    input logic [N-1:0] b_dig,
    input logic [N-1:0] res_dig,
    input logic         cout
);
    // operation captured from the ports alone
    logic         mode_seen;
    logic [N-1:0] b_held;
    logic [N-1:0] b_inv;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_seen <= 1'b1;
        end else if (sow) begin
            mode_seen <= add_mode;
        end
    end

    assign b_held = mode_seen ? b_dig : ~b_dig;
    assign b_inv  = ~b_dig;

    // R8: reset clears the registered outputs
    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (res_dig == '0 && cout == 1'b0));

    // R5 with R4: an add word starts from a zero carry
    assert_seed_add_R5: assert property (@(posedge clk) disable iff (rst)
        (sow && add_mode) |=>
            ({cout, res_dig} == ({1'b0, $past(a_dig)} + {1'b0, $past(b_dig)})));

    // R5 with R4: a subtract word starts from a carry of one with B inverted
    assert_seed_sub_R5: assert property (@(posedge clk) disable iff (rst)
        (sow && !add_mode) |=>
            ({cout, res_dig} == ({1'b0, $past(a_dig)} + {1'b0, $past(b_inv)} + (N+1)'(1))));

    // R2 and R6: later digits chain the registered carry under the captured mode
    assert_carry_chain_R2: assert property (@(posedge clk) disable iff (rst)
        !sow |=>
            ({cout, res_dig} == ({1'b0, $past(a_dig)} + {1'b0, $past(b_held)} + (N+1)'($past(cout)))));
endmodule

bind dsas_addsub dsas_addsub_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sow     (sow),
    .add_mode(add_mode),
    .a_dig   (a_dig),
    .b_dig   (b_dig),
    .res_dig (res_dig),
    .cout    (cout)
);

// File: tb/dsas_sweep.sv
module dsas_sweep #(
    parameter int W     = 6,
    parameter int N     = 2,
    parameter bit SERIAL = 1'b0
) (
    input  logic clk,
    output logic done,
    output int   total,
    output int   bad
);
    localparam int D = W / N;

    logic         rst;
    logic         sow;
    logic         add_mode;
    logic [N-1:0] a_dig;
    logic [N-1:0] b_dig;
    logic [N-1:0] res_dig;
    logic         cout;

    dsas_addsub #(.W(W), .N(N)) uut (
        .clk     (clk),
        .rst     (rst),
        .sow     (sow),
        .add_mode(add_mode),
        .a_dig   (a_dig),
        .b_dig   (b_dig),
        .res_dig (res_dig),
        .cout    (cout)
    );

    bit    pend;
    int    exp_d, exp_c, exp_word, pend_k;
    int    recv;
    string pend_tag;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // compare the digit registered on the previous edge
    task automatic settle();
        if (pend) begin
            chk(int'(res_dig) == exp_d, {pend_tag, " digit R1"}, int'(res_dig), exp_d);
            chk(int'(cout) == exp_c, {pend_tag, " carry R2"}, int'(cout), exp_c);
            recv = recv | (int'(res_dig) << (pend_k * N));
            if (pend_k == D - 1) begin
                chk(recv == exp_word, {pend_tag, " word R3 R4"}, recv, exp_word);
            end
            pend = 1'b0;
        end
    endtask

    task automatic drive(input int k, input int a, input int b, input bit op, input bit glitch);
        int wmask, lowm, bx, part;
        @(negedge clk);
        settle();
        if (k == 0) recv = 0;
        wmask    = (1 << W) - 1;
        lowm     = (1 << ((k + 1) * N)) - 1;
        rst      = 1'b0;
        sow      = (k == 0);
        add_mode = (k == 0) ? op : (glitch ? ~op : op);
        a_dig    = N'(a >> (k * N));
        b_dig    = N'(b >> (k * N));
        bx       = op ? b : (~b & wmask);
        part     = (a & lowm) + (bx & lowm) + (op ? 0 : 1);
        exp_d    = (part >> (k * N)) & ((1 << N) - 1);
        exp_c    = (part >> ((k + 1) * N)) & 1;
        exp_word = (op ? (a + b) : (a - b)) & wmask;
        pend_k   = k;
        pend_tag = $sformatf("%s%s%s a=%0d b=%0d k=%0d",
                             SERIAL ? "R7 " : "", (k == 0) ? "R5 " : "",
                             glitch ? "R6" : "R4", a, b, k);
        pend     = 1'b1;
    endtask

    initial begin
        done = 1'b0; total = 0; bad = 0; pend = 1'b0; recv = 0;
        rst = 1'b1; sow = 1'b0; add_mode = 1'b1; a_dig = '0; b_dig = '0;
        repeat (3) @(negedge clk);
        chk(res_dig == '0, "R8 reset digit", int'(res_dig), 0);
        chk(cout == 1'b0, "R8 reset carry", int'(cout), 0);

        // back-to-back words, every pair, both modes
        for (int op = 0; op < 2; op++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    for (int k = 0; k < D; k++) begin
                        drive(k, a, b, op[0], ((a ^ b) & 1) == 1);
                    end
                end
            end
        end

        // reset in the middle of a word that generates carries
        drive(0, (1 << W) - 1, 1, 1'b1, 1'b0);
        @(negedge clk);
        settle();
        rst = 1'b1;
        sow = 1'b0;
        @(negedge clk);
        chk(res_dig == '0, "R8 midword reset digit", int'(res_dig), 0);
        chk(cout == 1'b0, "R8 midword reset carry", int'(cout), 0);

        // operation resumes cleanly with a subtract word
        for (int k = 0; k < D; k++) begin
            drive(k, 1, 2, 1'b0, 1'b0);
        end
        @(negedge clk);
        settle();
        sow = 1'b0;
        done = 1'b1;
    end
endmodule

// File: tb/dsas_addsub_test.sv
`timescale 1ns/1ps
module dsas_addsub_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic d_dig, d_bit;
    int   t_dig, b_dig_cnt, t_bit, b_bit_cnt;

    // digit-wide configuration, three digits per word
    dsas_sweep #(.W(6), .N(2), .SERIAL(1'b0)) sw_dig (
        .clk(clk), .done(d_dig), .total(t_dig), .bad(b_dig_cnt)
    );

    // bit-serial configuration, four one-bit digits per word
    dsas_sweep #(.W(4), .N(1), .SERIAL(1'b1)) sw_bit (
        .clk(clk), .done(d_bit), .total(t_bit), .bad(b_bit_cnt)
    );

    initial begin
        int cyc;
        int tot;
        int nbad;
        cyc = 0;
        while (!(d_dig === 1'b1 && d_bit === 1'b1) && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        tot  = t_dig + t_bit;
        nbad = b_dig_cnt + b_bit_cnt;
        if (!(d_dig === 1'b1 && d_bit === 1'b1)) begin
            tot++;
            nbad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        end
        $display("test done: total=%0d bad=%0d", tot, nbad);
        $finish;
    end
endmodule